// File: doc/BRIEF.md
# Two-Pass Multiply-Add Datapath

This block computes A*B+C on unsigned operands of up to 64 bits. It uses a multiply array with only a 32-bit multiplier input. A narrow request uses the low 32 bits of each operand and makes a single pass through the array.

A wide request makes two passes. The first pass multiplies A by the low half of B, and the add stage folds C into that product. The second pass multiplies A by the high half of B, and the add stage adds that product, shifted up by 32 bits, to the running sum. The result is 128 bits wide, so nothing is truncated.

The pipeline has four stages: decode, multiply, add and writeback. Requests arrive on a valid/ready handshake. Results leave as a single-cycle strobe, in the order the requests were accepted.

Top module: `split_fma`

## Requirements
- R1: While reset is low, `res_valid` is 0 and `req_ready` is 1.
- R2: A narrow request (`req_wide`=0) returns a[31:0]*b[31:0]+c[31:0], zero-extended to 128 bits. Bits 63:32 of all three operands have no effect on the result.
- R3: A wide request (`req_wide`=1) returns the exact 128-bit value of a*b+c for 64-bit a, b and c.
- R4: On an otherwise idle pipeline, a narrow request accepted at clock edge k produces `res_valid` after edge k+3.
- R5: On an otherwise idle pipeline, a wide request accepted at clock edge k produces `res_valid` after edge k+4.
- R6: After a wide request is accepted on an idle pipeline, `req_ready` stays 1 for one cycle, is 0 for exactly one cycle (the second multiply pass), and then returns to 1. `req_ready` is never 0 in two consecutive cycles.
- R7: Each accepted request yields exactly one result. Results come out in acceptance order, and no result appears without an earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request is present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_wide | input | 1 | 1 = 64-bit two-pass operation, 0 = 32-bit single pass |
| req_a | input | 64 | Multiplicand A |
| req_b | input | 64 | Multiplier B, split into halves for wide operations |
| req_c | input | 64 | Addend C |
| res_valid | output | 1 | Single-cycle result strobe |
| res_data | output | 128 | A*B+C |

## Verification
Two things can land on the same cycle. The second multiply pass of a wide operation can coincide with a new request arriving at decode. The add stage can also be folding in the first-pass sum while the multiply stage computes the high-half product. A back-to-back stream of mixed narrow and wide requests provokes both, using corner operands (zero, all ones, single-bit powers of two) and random operands. The bench judges every result against an arithmetic model of A*B+C and checks that results keep acceptance order. Idle-pipeline probes measure the exact latency and confirm the single-cycle drop of `req_ready`.

// File: rtl/split_fma.sv
module split_fma #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_wide,
  input  logic [2*HW-1:0] req_a,
  input  logic [2*HW-1:0] req_b,
  input  logic [2*HW-1:0] req_c,
  output logic            res_valid,
  output logic [4*HW-1:0] res_data
);
  localparam int W  = 2 * HW;
  localparam int RW = 4 * HW;

  logic          d_v, d_wide;
  logic [W-1:0]  d_a, d_b, d_c;
  logic          m_v, m_wide, m_pass;
  logic [W-1:0]  m_a, m_c;
  logic [HW-1:0] m_bhi;
  logic [RW-1:0] m_prod;
  logic          a_v;
  logic [RW-1:0] a_acc;

  function automatic logic [RW-1:0] mul_half(input logic [W-1:0] x, input logic [HW-1:0] y);
    return {{(RW-W){1'b0}}, x} * {{(RW-HW){1'b0}}, y};
  endfunction

  wire hold   = m_v & m_wide & ~m_pass;
  wire m_last = ~m_wide | m_pass;
  assign req_ready = ~hold;

  wire [W-1:0]  dec_a   = d_wide ? d_a : {{HW{1'b0}}, d_a[HW-1:0]};
  wire [W-1:0]  dec_c   = d_wide ? d_c : {{HW{1'b0}}, d_c[HW-1:0]};
  wire [HW-1:0] dec_blo = d_b[HW-1:0];
  wire [HW-1:0] dec_bhi = d_wide ? d_b[W-1:HW] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_v <= 1'b0;
      m_v <= 1'b0;
      m_pass <= 1'b0;
      m_wide <= 1'b0;
      a_v <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (!hold) begin
        d_v    <= req_valid;
        m_v    <= d_v;
        m_wide <= d_wide;
        m_pass <= 1'b0;
      end else begin
        m_pass <= 1'b1;
      end
      a_v       <= m_v & m_last;
      res_valid <= a_v;
    end

  always_ff @(posedge clk) begin
    if (!hold && req_valid) begin
      d_wide <= req_wide;
      d_a    <= req_a;
      d_b    <= req_b;
      d_c    <= req_c;
    end
    if (hold) begin
      m_prod <= mul_half(m_a, m_bhi);
    end else begin
      m_a    <= dec_a;
      m_c    <= dec_c;
      m_bhi  <= dec_bhi;
      m_prod <= mul_half(dec_a, dec_blo);
    end
    if (m_v)
      a_acc <= m_pass ? a_acc + (m_prod << HW) : m_prod + {{(RW-W){1'b0}}, m_c};
    if (a_v)
      res_data <= a_acc;
  end
endmodule

module split_fma_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid
);
  logic [3:0] inflight;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + {3'b0, req_valid & req_ready} - {3'b0, res_valid};

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !res_valid);

  // R6
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  // R7
  no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> inflight != 4'd0);

  // R7
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'd4);
endmodule

bind split_fma split_fma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_ready(req_ready), .res_valid(res_valid)
);

// File: tb/split_fma_tb.sv
module split_fma_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, req_valid, req_ready, req_wide, res_valid;
  logic [63:0]  req_a, req_b, req_c;
  logic [127:0] res_data;

  split_fma u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_a(req_a), .req_b(req_b), .req_c(req_c),
    .res_valid(res_valid), .res_data(res_data)
  );

  int total = 0, bad = 0, cyc = 0, wr = 0, rd = 0;
  bit done = 0;
  logic [127:0] exp_q [0:1023];
  bit           wide_q[0:1023];
  int           acc_q [0:1023];
  int           lat_q [0:1023];
  logic [63:0]  corner[0:6];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] model(logic [63:0] a, logic [63:0] b, logic [63:0] c, bit w);
    if (w) return {64'b0, a} * {64'b0, b} + {64'b0, c};
    return {96'b0, a[31:0]} * {96'b0, b[31:0]} + {96'b0, c[31:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // caller is at a negedge; returns at the negedge after acceptance with valid still high
  task automatic send(logic [63:0] a, logic [63:0] b, logic [63:0] c, bit w, int lat);
    req_valid = 1'b1; req_wide = w; req_a = a; req_b = b; req_c = c;
    while (!req_ready) @(negedge clk);
    exp_q[wr] = model(a, b, c, w);
    wide_q[wr] = w;
    acc_q[wr] = cyc + 1;
    lat_q[wr] = lat;
    wr++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (rd >= wr) chk(0, "R7 extra result", 128'(rd), 128'(wr));
      else begin
        if (wide_q[rd]) chk(res_data == exp_q[rd], "R3 wide value", res_data, exp_q[rd]);
        else            chk(res_data == exp_q[rd], "R2 narrow value", res_data, exp_q[rd]);
        if (lat_q[rd] == 3) chk(cyc - acc_q[rd] == 3, "R4 narrow latency", 128'(cyc - acc_q[rd]), 128'd3);
        if (lat_q[rd] == 4) chk(cyc - acc_q[rd] == 4, "R5 wide latency", 128'(cyc - acc_q[rd]), 128'd4);
        rd++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog: results=%0d expected=%0d", rd, wr);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    corner[0] = 64'h0;                corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[2] = 64'h1;                corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h1_0000_0000;      corner[5] = 64'h8000_0000;
    corner[6] = 64'hFFFF_FFFF;
    rst_n = 1'b0; req_valid = 1'b0; req_wide = 1'b0;
    req_a = '0; req_b = '0; req_c = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 reset res_valid", 128'(res_valid), 128'd0);
    chk(req_ready == 1'b1, "R1 reset req_ready", 128'(req_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // isolated latency probes, narrow with junk upper bits (R2, R4)
    send(64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 64'hABCD_0000_FFFF_FFFF, 0, 3); idle(6);
    send(64'h5, 64'h7, 64'h9, 0, 3); idle(6);
    // isolated wide with ready probe (R5, R6)
    for (int i = 0; i < 3; i++) begin
      send(corner[i+1], corner[6-i], corner[i], 1, 4);
      req_valid = 1'b0;
      chk(req_ready == 1'b1, "R6 ready before second pass", 128'(req_ready), 128'd1);
      @(negedge clk);
      chk(req_ready == 1'b0, "R6 ready in second pass", 128'(req_ready), 128'd0);
      @(negedge clk);
      chk(req_ready == 1'b1, "R6 ready after second pass", 128'(req_ready), 128'd1);
      idle(6);
    end

    // corner sweep, streamed back to back, alternating widths (R2, R3, R7)
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 3; c++) begin
          send(corner[a], corner[b], corner[c*3], 1, 0);
          send(corner[a], corner[b], corner[c*3], 0, 0);
        end
    idle(8);

    // random mixed stream with occasional gaps (R2, R3, R7)
    for (int i = 0; i < 240; i++) begin
      send({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, $urandom % 2, 0);
      if ($urandom % 5 == 0) idle(1);
    end
    idle(10);

    chk(rd == wr, "R7 result count", 128'(rd), 128'(wr));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule